// File: doc/BRIEF.md
# Synthesizer Latch Programming Controller

This block is the digital programming front end of a frequency synthesizer. A host shifts a 24-bit control word in serially, most significant bit first, and then raises a load strobe. The two lowest bits of the word pick the destination: the reference-divider word, the AB-divider word, the function settings, or the initialization latch. The initialization latch writes the function settings and also starts an alignment sequence.

From the stored settings the block drives the control side effects that the divider and charge-pump logic need. It raises a counter-reset request that holds the reference, AB and timeout counters at their load point. It raises a charge-pump high-impedance request and a power-down request. The counter-reset request is a one-cycle pulse after an initialization write and again after the first AB write that follows it. It also stays high for as long as the programmable counter-reset bit is set. The enable input forces power-down at once, with no clock needed, and all stored words are kept while it is low.

The serial clock, data and strobe are sampled by the system clock and are assumed to be synchronous to it already. Each one must stay stable for at least one system clock cycle per level.

Top module: `synth_prog_ctrl`

## Requirements
- R1: A bit is shifted in on each rising edge of `sclk`, with the most significant bit arriving first. On a rising edge of `le` the 24-bit word is stored according to its bits [1:0]: 00 stores bits [23:2] in `ref_word`, 01 stores them in `ab_word`, 10 stores them in `fn_word`. Latches that are not selected keep their contents.
- R2: Selector 11 (the initialization latch) also stores bits [23:2] in `fn_word`, and therefore in every decoded field.
- R3: An initialization write raises `ctr_rst` for exactly one system clock cycle, starting in the cycle after the load edge. `cp_hiz` is high during that cycle.
- R4: The first AB write after an initialization write gives the same one-cycle `ctr_rst` pulse. Later AB writes give no pulse until another initialization write occurs.
- R5: Word bit 2 is the counter-reset bit. While it is 1, `ctr_rst` and `cp_hiz` stay high and no power-down is started.
- R6: Word bit 4 is the charge-pump three-state bit. When it is 1, `cp_hiz` is high. When it is 0, `cp_hiz` follows only the other causes.
- R7: Synchronous power-down mode is word bit 3 = 1 together with bit 16 = 0. If a reset pulse occurs while this mode is set and `ce` is high, `pwr_down` rises one cycle after the pulse. It stays high until the function settings leave that mode.
- R8: `ce` low drives `pwr_down` high at once, with no clock edge needed. No stored word changes, so after `ce` returns high the earlier settings are still in force.
- R9: `timer_en` equals word bit 10 of the function settings, which selects fastlock mode 2.
- R10: The function settings are decoded into these fields: `cp_cur1` is bits [8:6], `cp_cur2` is bits [13:11], `presc_sel` is bits [15:14] and `pd_polarity` is bit 5.
- R11: While `rst_n` is low, all stored words are zero, the pending-AB flag is clear, `ctr_rst` is low, `cp_hiz` is high (until the first function or initialization write) and `pwr_down` is low while `ce` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ce | input | 1 | Chip enable; low forces power-down |
| sclk | input | 1 | Serial shift clock (sampled) |
| sdata | input | 1 | Serial data, most significant bit first |
| le | input | 1 | Load strobe; rising edge stores the word |
| ref_word | output | 22 | Stored reference-divider word |
| ab_word | output | 22 | Stored AB-divider word |
| fn_word | output | 22 | Stored function settings |
| cp_cur1 | output | 3 | Charge-pump current setting 1 |
| cp_cur2 | output | 3 | Charge-pump current setting 2 |
| presc_sel | output | 2 | Prescaler selection |
| pd_polarity | output | 1 | Phase-detector polarity |
| timer_en | output | 1 | Timeout timer enable (fastlock mode 2) |
| ctr_rst | output | 1 | Counter reset request (reference, AB, timeout) |
| cp_hiz | output | 1 | Charge-pump three-state request |
| pwr_down | output | 1 | Power-down request |

## Verification
Stored words and decoded fields change in the cycle that follows the system clock edge at which a rising `le` is first seen. The reset pulse comes one cycle after that, and a synchronous power-down one cycle after the pulse. The reference model updates at the same edges, and every output is compared in the middle of each low clock phase, with inputs driven just after the falling edge. The direct path from `ce` to `pwr_down` is also checked within a cycle, with no clock edge in between.

// File: rtl/synth_prog_ctrl.sv
module synth_prog_ctrl #(
  parameter int WORD_W = 24,
  parameter int CUR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              le,
  output logic [WORD_W-3:0] ref_word,
  output logic [WORD_W-3:0] ab_word,
  output logic [WORD_W-3:0] fn_word,
  output logic [CUR_W-1:0]  cp_cur1,
  output logic [CUR_W-1:0]  cp_cur2,
  output logic [1:0]        presc_sel,
  output logic              pd_polarity,
  output logic              timer_en,
  output logic              ctr_rst,
  output logic              cp_hiz,
  output logic              pwr_down
);
  localparam int B_CRST = 2;
  localparam int B_PD1  = 3;
  localparam int B_TRI  = 4;
  localparam int B_POL  = 5;
  localparam int B_CUR1 = 6;
  localparam int B_FL   = 10;
  localparam int B_CUR2 = 11;
  localparam int B_PRE  = 14;
  localparam int B_PD2  = 16;

  logic [WORD_W-1:0] sr;
  logic [WORD_W-1:2] ref_q, ab_q, fn_q;
  logic sclk_q, le_q, ab_pend, rst_pulse, spd_q, armed;

  wire shift_en  = sclk & ~sclk_q;
  wire load_en   = le & ~le_q;
  wire ld_ref    = load_en && sr[1:0] == 2'b00;
  wire ld_ab     = load_en && sr[1:0] == 2'b01;
  wire ld_fn     = load_en && sr[1:0] == 2'b10;
  wire ld_init   = load_en && sr[1:0] == 2'b11;
  wire sync_mode = fn_q[B_PD1] & ~fn_q[B_PD2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr     <= '0;
      sclk_q <= 1'b0;
      le_q   <= 1'b0;
    end else begin
      sclk_q <= sclk;
      le_q   <= le;
      if (shift_en) sr <= {sr[WORD_W-2:0], sdata};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_q <= '0;
      ab_q  <= '0;
      fn_q  <= '0;
      armed <= 1'b0;
    end else begin
      if (ld_ref) ref_q <= sr[WORD_W-1:2];
      if (ld_ab)  ab_q  <= sr[WORD_W-1:2];
      if (ld_fn || ld_init) begin
        fn_q  <= sr[WORD_W-1:2];
        armed <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_pulse <= 1'b0;
      ab_pend   <= 1'b0;
      spd_q     <= 1'b0;
    end else begin
      rst_pulse <= ld_init | (ld_ab & ab_pend);
      if (ld_init)    ab_pend <= 1'b1;
      else if (ld_ab) ab_pend <= 1'b0;
      if (rst_pulse && ce && sync_mode) spd_q <= 1'b1;
      else if (!sync_mode)              spd_q <= 1'b0;
    end

  assign ref_word    = ref_q;
  assign ab_word     = ab_q;
  assign fn_word     = fn_q;
  assign cp_cur1     = fn_q[B_CUR1 +: CUR_W];
  assign cp_cur2     = fn_q[B_CUR2 +: CUR_W];
  assign presc_sel   = fn_q[B_PRE +: 2];
  assign pd_polarity = fn_q[B_POL];
  assign timer_en    = fn_q[B_FL];
  assign ctr_rst     = rst_pulse | fn_q[B_CRST];
  assign cp_hiz      = ~armed | ctr_rst | fn_q[B_TRI];
  assign pwr_down    = ~ce | spd_q;

  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ld_ref |=> $stable(ref_word)); // R1
  AST_INIT_COPIES_FN: assert property (@(posedge clk) disable iff (!rst_n) ld_init |=> fn_word == $past(sr[WORD_W-1:2])); // R2
  AST_INIT_FIRES: assert property (@(posedge clk) disable iff (!rst_n) ld_init |=> rst_pulse); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rst_pulse |=> !rst_pulse); // R3
  AST_RST_HIZ: assert property (@(posedge clk) disable iff (!rst_n) ctr_rst |-> cp_hiz); // R3
  AST_AB_LATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (ld_ab && !ab_pend) |=> !rst_pulse); // R4
  AST_CE_LOW_PD: assert property (@(posedge clk) disable iff (!rst_n) !ce |-> pwr_down); // R8
endmodule

// File: tb/sim_synth_prog_ctrl.sv
module sim_synth_prog_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b1, sclk = 1'b0, sdata = 1'b0, le = 1'b0;
  logic [21:0] ref_word, ab_word, fn_word;
  logic [2:0]  cp_cur1, cp_cur2;
  logic [1:0]  presc_sel;
  logic pd_polarity, timer_en, ctr_rst, cp_hiz, pwr_down;
  int n_chk = 0, n_fail = 0, cyc = 0, pulse_cnt = 0;

  always #4 clk = ~clk;

  synth_prog_ctrl u0 (.clk, .rst_n, .ce, .sclk, .sdata, .le, .ref_word, .ab_word, .fn_word,
    .cp_cur1, .cp_cur2, .presc_sel, .pd_polarity, .timer_en, .ctr_rst, .cp_hiz, .pwr_down);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // behavioural reference model
  logic [23:0] m_sr;
  logic [21:0] m_ref, m_ab, m_fn;
  logic m_sq, m_lq, m_pend, m_pulse, m_spd, m_armed;
  always @(posedge clk or negedge rst_n) begin
    logic lr, sh, mode;
    if (!rst_n) begin
      m_sr = 0; m_ref = 0; m_ab = 0; m_fn = 0;
      m_sq = 0; m_lq = 0; m_pend = 0; m_pulse = 0; m_spd = 0; m_armed = 0;
    end else begin
      lr = le && !m_lq;
      sh = sclk && !m_sq;
      mode = m_fn[1] && !m_fn[14];
      if (m_pulse && ce && mode) m_spd = 1;
      else if (!mode) m_spd = 0;
      m_pulse = 0;
      if (lr) begin
        case (m_sr[1:0])
          2'd0: m_ref = m_sr[23:2];
          2'd1: begin m_ab = m_sr[23:2]; if (m_pend) begin m_pulse = 1; m_pend = 0; end end
          2'd2: begin m_fn = m_sr[23:2]; m_armed = 1; end
          default: begin m_fn = m_sr[23:2]; m_armed = 1; m_pulse = 1; m_pend = 1; end
        endcase
      end
      if (sh) m_sr = {m_sr[22:0], sdata};
      m_sq = sclk;
      m_lq = le;
    end
  end

  always @(negedge clk) begin
    logic e_rst;
    cyc++;
    if (ctr_rst) pulse_cnt++;
    e_rst = m_pulse | m_fn[0];
    check("R1 ref_word", 32'(ref_word), 32'(m_ref));
    check("R1 ab_word", 32'(ab_word), 32'(m_ab));
    check("R10 fn_word", 32'(fn_word), 32'(m_fn));
    check("R10 cp_cur1", 32'(cp_cur1), 32'(m_fn[6:4]));
    check("R10 cp_cur2", 32'(cp_cur2), 32'(m_fn[11:9]));
    check("R10 presc_sel", 32'(presc_sel), 32'(m_fn[13:12]));
    check("R10 pd_polarity", 32'(pd_polarity), 32'(m_fn[3]));
    check("R9 timer_en", 32'(timer_en), 32'(m_fn[8]));
    check("R3 ctr_rst", 32'(ctr_rst), 32'(e_rst));
    check("R6 cp_hiz", 32'(cp_hiz), 32'(!m_armed | e_rst | m_fn[2]));
    check("R7 pwr_down", 32'(pwr_down), 32'(!ce | m_spd));
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
      finish_run();
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic send(logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      sdata = w[i]; sclk = 1'b0; tick();
      sclk = 1'b1; tick();
    end
    sclk = 1'b0; tick();
    le = 1'b1; tick();
    le = 1'b0; tick(3);
  endtask

  function automatic logic [23:0] fw(bit crst, bit pd1, bit tri_b, bit pol, logic [2:0] c1,
                                     bit fl, logic [2:0] c2, logic [1:0] pre, bit pd2);
    logic [23:0] w = 24'h0;
    w[1:0] = 2'b10; w[2] = crst; w[3] = pd1; w[4] = tri_b; w[5] = pol;
    w[8:6] = c1; w[10] = fl; w[13:11] = c2; w[15:14] = pre; w[16] = pd2;
    return w;
  endfunction

  initial begin
    tick(3);
    check("R11 reset ref", 32'(ref_word), 0);
    check("R11 reset ctr_rst", 32'(ctr_rst), 0);
    check("R11 reset cp_hiz", 32'(cp_hiz), 1);
    check("R11 reset pwr_down", 32'(pwr_down), 0);
    rst_n = 1'b1; tick(2);
    send({22'h2A5C3, 2'b00});
    check("R1 ref routed", 32'(ref_word), 32'h2A5C3);
    pulse_cnt = 0;
    send({22'h15A5A, 2'b01});
    check("R4 AB without init: no pulse", pulse_cnt, 0);
    send(fw(0, 0, 0, 1, 3'd5, 1, 3'd2, 2'd3, 0));
    check("R10 cp_cur1 decode", 32'(cp_cur1), 5);
    check("R9 timer_en set", 32'(timer_en), 1);
    pulse_cnt = 0;
    send(fw(0, 1, 0, 0, 3'd6, 0, 3'd1, 2'd1, 0) | 24'h3);
    check("R2 init writes fn", 32'(cp_cur1), 6);
    check("R3 init pulse count", pulse_cnt, 1);
    check("R7 sync power-down", 32'(pwr_down), 1);
    send(fw(0, 0, 0, 0, 3'd6, 0, 3'd1, 2'd1, 0));
    check("R7 leave mode clears", 32'(pwr_down), 0);
    pulse_cnt = 0;
    send({22'h00111, 2'b01});
    check("R4 first AB pulse", pulse_cnt, 1);
    pulse_cnt = 0;
    send({22'h00222, 2'b01});
    check("R4 second AB no pulse", pulse_cnt, 0);
    send(fw(1, 1, 0, 0, 3'd1, 0, 3'd1, 2'd0, 0));
    check("R5 counter reset held", 32'(ctr_rst), 1);
    check("R5 counter reset hiz", 32'(cp_hiz), 1);
    check("R5 no power-down", 32'(pwr_down), 0);
    send(fw(0, 0, 1, 0, 3'd1, 0, 3'd1, 2'd0, 0));
    check("R6 three-state bit", 32'(cp_hiz), 1);
    send(fw(0, 0, 0, 0, 3'd1, 0, 3'd1, 2'd0, 1));
    check("R6 cp enabled", 32'(cp_hiz), 0);
    #2 ce = 1'b0;
    #1 check("R8 async power-down", 32'(pwr_down), 1);
    tick(5);
    ce = 1'b1; tick(2);
    check("R8 ab retained", 32'(ab_word), 32'h00222);
    check("R8 pwr_down released", 32'(pwr_down), 0);
    pulse_cnt = 0;
    send(fw(0, 0, 0, 0, 3'd7, 1, 3'd7, 2'd2, 0) | 24'h3);
    send({22'h3FFFF, 2'b01});
    check("R4 re-armed by init", pulse_cnt, 2);
    tick(4);
    finish_run();
  end
endmodule